// File: doc/BRIEF.md
# NAND Page-Read Pointer Sequencer

This block models the read side of a small-page NAND flash device. The host writes bus cycles on an 8-bit input bus, and the block samples each cycle on the rising edge of the write strobe. The command latch and address latch flags mark a cycle as a command or as an address. A read setup is one command cycle followed by three address cycles. The command selects where the column pointer starts:

- the first half of a 528-byte page;
- the second half of the page;
- the 16-byte spare tail.

The address cycles give the start column and the row. Once setup is complete, the block copies the addressed page from a computed array into an internal page buffer, and the ready output stays low while that copy runs. After ready returns high, each falling edge of the read strobe puts the byte at the current column on the output and moves the pointer forward by one column.

When the last column of the page has been output, the block moves to the next row by itself and starts a new load, so reading runs on across page boundaries. Raising the chip enable ends such a sequence. A strap input selects whether the spare tail is part of a normal read. The second-half pointer applies to one read only. The spare pointer stays in force until a first-half or second-half command is written.

Top module: `nand_rd_seq`

## Requirements
- R1: After reset, ready is 1 and io_out is 0. The pointer mode is first-half, so three address cycles sent with no command start reading at the column given by the first address byte.
- R2: Command 00h followed by three address cycles starts at column A, where A is the first address byte. The row is the second byte, plus the low 6 bits of the third byte times 256. The byte stored at row r, column c is (7*r + c + 3*floor(c/256)) mod 256.
- R3: ready is low for exactly TR_CYCLES+2 clocks after the third address cycle. It is low for exactly TR_CYCLES+1 clocks after the read strobe falls on the last column of a page.
- R4: Each falling edge of re_n, while ready is high, outputs the byte at the current column and advances the column by one.
- R5: The last column of a page is 527 when skip_spare is 0 and 511 when skip_spare is 1. After the last column, the row increments and reading restarts at column 0.
- R6: Command 01h starts at column 256+A. The next page of that sequence starts at column 0, and a later setup sent with no command uses the first-half mode.
- R7: Command 50h starts at column 512 plus the low 4 bits of A, and the high 4 bits of A are ignored. The last column is always 527, and each following page restarts at column 512. The mode stays in force for setups with no command until 00h or 01h is written.
- R8: While ce_n is high, read strobes leave io_out unchanged and start no load. After ce_n returns low, no byte is output until a new setup.
- R9: Command and address cycles written while ready is low have no effect.
- R10: A cycle with cle and ale both high is discarded. A command code other than 00h, 01h or 50h changes nothing.
- R11: Read strobes while ready is low leave io_out and the column pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Active-low chip enable; high ends a read sequence |
| cle | input | 1 | Marks the current bus cycle as a command |
| ale | input | 1 | Marks the current bus cycle as an address |
| we_n | input | 1 | Write strobe; its rising edge latches io_in |
| re_n | input | 1 | Read strobe; its falling edge outputs a byte |
| skip_spare | input | 1 | Strap: 1 ends normal reads at column 511 |
| io_in | input | 8 | Command or address byte |
| io_out | output | 8 | Last byte read out |
| ready | output | 1 | Low while a setup or page load is in progress |

## Verification
The assertions assume the following about the inputs:

- The bus strobes and latch flags are synchronous to clk, and each level is held for at least one full clock.
- cle and ale only change while we_n is low or between cycles.
- skip_spare is only changed between read sequences.

Under these assumptions, every strobe edge is seen exactly once, and a read can only start from a loaded page. The bench drives all inputs on falling clock edges and holds every strobe level for a full clock. It changes the strap only before a setup, both in the directed cases and in the seeded random runs.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;

   typedef enum logic [1:0] {
      RG_FIRST  = 2'd0,
      RG_SECOND = 2'd1,
      RG_SPARE  = 2'd2
   } region_e;

   localparam logic [7:0] CMD_RD_FIRST  = 8'h00;
   localparam logic [7:0] CMD_RD_SECOND = 8'h01;
   localparam logic [7:0] CMD_RD_SPARE  = 8'h50;

   // Synthetic array content: (7*row + col + 3*(col/256)) mod 256
   function automatic logic [7:0] cell_byte(input logic [15:0] row, input logic [9:0] col);
      return 8'(row * 16'd7 + {6'd0, col} + {14'd0, col[9:8]} * 16'd3);
   endfunction

endpackage

// File: rtl/nand_cycle_dec.sv
module nand_cycle_dec
   import nand_rd_pkg::*;
#(
   parameter int IO_W        = 8,
   parameter int ROW_W       = 14,
   parameter int COL_W       = 10,
   parameter int HALF_BYTES  = 256,
   parameter int MAIN_BYTES  = 512,
   parameter int SPARE_BYTES = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ce_n,
   input  logic             cle,
   input  logic             ale,
   input  logic             we_n,
   input  logic [IO_W-1:0]  io_in,
   input  logic             hold,
   output logic             setup_pulse,
   output region_e          setup_region,
   output logic [COL_W-1:0] setup_col,
   output logic [ROW_W-1:0] setup_row
);
   localparam int HI_W = ROW_W - IO_W;
   localparam int SP_W = $clog2(SPARE_BYTES);

   logic            we_q;
   logic [1:0]      addr_cnt;
   logic [IO_W-1:0] col_byte;
   logic [IO_W-1:0] row_lo;
   region_e         region_q;
   logic            take, is_cmd, is_addr;
   logic [COL_W-1:0] start_col;

   assign take    = we_n & ~we_q & ~ce_n & ~hold;
   assign is_cmd  = take & cle & ~ale;
   assign is_addr = take & ale & ~cle;

   always_comb begin
      case (region_q)
         RG_SECOND: start_col = COL_W'(HALF_BYTES) + COL_W'(col_byte);
         RG_SPARE:  start_col = COL_W'(MAIN_BYTES) + COL_W'(col_byte[SP_W-1:0]);
         default:   start_col = COL_W'(col_byte);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_q         <= 1'b1;
         addr_cnt     <= 2'd0;
         col_byte     <= '0;
         row_lo       <= '0;
         region_q     <= RG_FIRST;
         setup_pulse  <= 1'b0;
         setup_region <= RG_FIRST;
         setup_col    <= '0;
         setup_row    <= '0;
      end else begin
         we_q        <= we_n;
         setup_pulse <= 1'b0;
         if (ce_n) begin
            addr_cnt <= 2'd0;
         end else if (is_cmd) begin
            case (io_in)
               CMD_RD_FIRST:  begin region_q <= RG_FIRST;  addr_cnt <= 2'd0; end
               CMD_RD_SECOND: begin region_q <= RG_SECOND; addr_cnt <= 2'd0; end
               CMD_RD_SPARE:  begin region_q <= RG_SPARE;  addr_cnt <= 2'd0; end
               default: ;
            endcase
         end else if (is_addr) begin
            case (addr_cnt)
               2'd0: begin col_byte <= io_in; addr_cnt <= 2'd1; end
               2'd1: begin row_lo   <= io_in; addr_cnt <= 2'd2; end
               default: begin
                  setup_pulse  <= 1'b1;
                  setup_region <= region_q;
                  setup_col    <= start_col;
                  setup_row    <= {io_in[HI_W-1:0], row_lo};
                  addr_cnt     <= 2'd0;
                  if (region_q == RG_SECOND) region_q <= RG_FIRST;
               end
            endcase
         end
      end
   end

   // R6: second-half pointer is consumed by the setup that used it
   p_oneshot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (setup_pulse && setup_region == RG_SECOND) |-> (region_q == RG_FIRST));

   // R9: nothing moves while the downstream path is busy
   p_ignore_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !ce_n) |=> ($stable(addr_cnt) && $stable(region_q) && !setup_pulse));

endmodule

// File: rtl/nand_page_buf.sv
module nand_page_buf
   import nand_rd_pkg::*;
#(
   parameter int ROW_W      = 14,
   parameter int COL_W      = 10,
   parameter int PAGE_BYTES = 528,
   parameter int TR_CYCLES  = 600
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_req,
   input  logic [ROW_W-1:0] load_row,
   input  logic [COL_W-1:0] rd_col,
   output logic             busy,
   output logic [7:0]       rd_byte
);
   localparam int CNT_W = $clog2(TR_CYCLES + 1);

   logic [7:0]       mem [PAGE_BYTES];
   logic [CNT_W-1:0] cnt;
   logic [ROW_W-1:0] row_l;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt   <= '0;
         row_l <= '0;
      end else if (load_req) begin
         busy  <= 1'b1;
         cnt   <= '0;
         row_l <= load_row;
      end else if (busy) begin
         cnt <= cnt + 1'b1;
         if (cnt == CNT_W'(TR_CYCLES - 1)) busy <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (busy && (cnt < CNT_W'(PAGE_BYTES)))
         mem[cnt[COL_W-1:0]] <= cell_byte(16'(row_l), 10'(cnt));
   end

   assign rd_byte = mem[rd_col];

   // R3: a load lasts exactly TR_CYCLES clocks
   p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(cnt) == CNT_W'(TR_CYCLES - 1)));

   // R3: the pointer never requests a load on top of a running one
   p_req_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      load_req |-> !busy);

endmodule

// File: rtl/nand_col_ptr.sv
module nand_col_ptr
   import nand_rd_pkg::*;
#(
   parameter int IO_W       = 8,
   parameter int ROW_W      = 14,
   parameter int COL_W      = 10,
   parameter int MAIN_BYTES = 512,
   parameter int PAGE_BYTES = 528
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ce_n,
   input  logic             re_n,
   input  logic             skip_spare,
   input  logic             busy,
   input  logic             setup_pulse,
   input  region_e          setup_region,
   input  logic [COL_W-1:0] setup_col,
   input  logic [ROW_W-1:0] setup_row,
   input  logic [IO_W-1:0]  rd_byte,
   output logic [COL_W-1:0] rd_col,
   output logic             load_req,
   output logic [ROW_W-1:0] load_row,
   output logic [IO_W-1:0]  io_out
);
   localparam logic [COL_W-1:0] LAST_FULL = COL_W'(PAGE_BYTES - 1);
   localparam logic [COL_W-1:0] LAST_MAIN = COL_W'(MAIN_BYTES - 1);
   localparam logic [COL_W-1:0] SPARE_0   = COL_W'(MAIN_BYTES);

   logic             re_q;
   logic [COL_W-1:0] col;
   logic [ROW_W-1:0] row;
   logic             spare_mode;
   logic             active;
   logic [COL_W-1:0] end_col;
   logic             rd_go;

   assign end_col  = (spare_mode || !skip_spare) ? LAST_FULL : LAST_MAIN;
   assign rd_go    = re_q & ~re_n & active & ~busy & ~load_req & ~setup_pulse & ~ce_n;
   assign rd_col   = col;
   assign load_row = row;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         re_q       <= 1'b1;
         col        <= '0;
         row        <= '0;
         spare_mode <= 1'b0;
         active     <= 1'b0;
         load_req   <= 1'b0;
         io_out     <= '0;
      end else begin
         re_q     <= re_n;
         load_req <= 1'b0;
         if (ce_n) begin
            active <= 1'b0;
         end else if (setup_pulse) begin
            col        <= setup_col;
            row        <= setup_row;
            spare_mode <= (setup_region == RG_SPARE);
            active     <= 1'b1;
            load_req   <= 1'b1;
         end else if (rd_go) begin
            io_out <= rd_byte;
            if (col == end_col) begin
               row      <= row + 1'b1;
               col      <= spare_mode ? SPARE_0 : '0;
               load_req <= 1'b1;
            end else begin
               col <= col + 1'b1;
            end
         end
      end
   end

   // R4: an ordinary read step moves the pointer by one column
   p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_go && col != end_col) |=> (col == $past(col) + 1'b1));

   // R5: the end column triggers a next-page load and a region restart
   p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_go && col == end_col) |=> (load_req && (col == '0 || col == SPARE_0)));

   // R11: output frozen while a page load runs
   p_hold_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(io_out));

   // R5: pointer never leaves the page
   p_col_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (col <= LAST_FULL));

endmodule

// File: rtl/nand_rd_seq.sv
module nand_rd_seq
   import nand_rd_pkg::*;
#(
   parameter int IO_W        = 8,
   parameter int ROW_W       = 14,
   parameter int MAIN_BYTES  = 512,
   parameter int SPARE_BYTES = 16,
   parameter int TR_CYCLES   = 600
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ce_n,
   input  logic            cle,
   input  logic            ale,
   input  logic            we_n,
   input  logic            re_n,
   input  logic            skip_spare,
   input  logic [IO_W-1:0] io_in,
   output logic [IO_W-1:0] io_out,
   output logic            ready
);
   localparam int PAGE_BYTES = MAIN_BYTES + SPARE_BYTES;
   localparam int HALF_BYTES = MAIN_BYTES / 2;
   localparam int COL_W      = $clog2(PAGE_BYTES);

   if (IO_W != 8) begin : g_bad_io
      $error("bus width must be 8");
   end
   if (HALF_BYTES != 2 ** IO_W) begin : g_bad_half
      $error("half page must be addressable by one address byte");
   end
   if (ROW_W <= IO_W || ROW_W > 16) begin : g_bad_row
      $error("row width must lie in 9..16");
   end
   if (SPARE_BYTES < 2 || SPARE_BYTES > 2 ** IO_W || (SPARE_BYTES & (SPARE_BYTES - 1)) != 0) begin : g_bad_spare
      $error("spare size must be a power of two within one address byte");
   end
   if (TR_CYCLES < PAGE_BYTES) begin : g_bad_tr
      $error("load time must cover one byte copy per clock");
   end

   logic             setup_pulse;
   region_e          setup_region;
   logic [COL_W-1:0] setup_col;
   logic [ROW_W-1:0] setup_row;
   logic             load_req;
   logic [ROW_W-1:0] load_row;
   logic [COL_W-1:0] rd_col;
   logic [7:0]       rd_byte;
   logic             busy;
   logic             hold;

   assign hold  = busy | load_req | setup_pulse;
   assign ready = ~hold;

   nand_cycle_dec #(
      .IO_W(IO_W), .ROW_W(ROW_W), .COL_W(COL_W), .HALF_BYTES(HALF_BYTES),
      .MAIN_BYTES(MAIN_BYTES), .SPARE_BYTES(SPARE_BYTES)
   ) u_dec (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
      .io_in(io_in), .hold(hold), .setup_pulse(setup_pulse),
      .setup_region(setup_region), .setup_col(setup_col), .setup_row(setup_row)
   );

   nand_col_ptr #(
      .IO_W(IO_W), .ROW_W(ROW_W), .COL_W(COL_W),
      .MAIN_BYTES(MAIN_BYTES), .PAGE_BYTES(PAGE_BYTES)
   ) u_ptr (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .re_n(re_n), .skip_spare(skip_spare),
      .busy(busy), .setup_pulse(setup_pulse), .setup_region(setup_region),
      .setup_col(setup_col), .setup_row(setup_row), .rd_byte(rd_byte),
      .rd_col(rd_col), .load_req(load_req), .load_row(load_row), .io_out(io_out)
   );

   nand_page_buf #(
      .ROW_W(ROW_W), .COL_W(COL_W), .PAGE_BYTES(PAGE_BYTES), .TR_CYCLES(TR_CYCLES)
   ) u_buf (
      .clk(clk), .rst_n(rst_n), .load_req(load_req), .load_row(load_row),
      .rd_col(rd_col), .busy(busy), .rd_byte(rd_byte)
   );

endmodule

// File: tb/nand_rd_seq_bench.sv
module nand_rd_seq_bench;
   localparam int TR = 600;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ce_n = 1'b0, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1;
   logic       skip_spare = 1'b1;
   logic [7:0] io_in = 8'h00;
   logic [7:0] io_out;
   logic       ready;

   always #4 clk = ~clk;

   nand_rd_seq #(.TR_CYCLES(TR)) u_nand_rd_seq (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
      .re_n(re_n), .skip_spare(skip_spare), .io_in(io_in), .io_out(io_out), .ready(ready)
   );

   int n_chk = 0;
   int n_err = 0;
   bit done  = 0;

   // bench model of the pointer
   int m_region = 0;   // 0 first half, 1 second half, 2 spare
   int m_col = 0;
   int m_row = 0;
   int m_spare = 0;

   function automatic logic [7:0] exp_byte(int r, int c);
      int v;
      v = r * 7 + c + (c / 256) * 3;
      return v[7:0];
   endfunction

   function automatic int last_col(int sp, logic sk);
      return (sp != 0 || !sk) ? 527 : 511;
   endfunction

   function automatic int first_col(int rg, int cb);
      if (rg == 1) return 256 + cb;
      if (rg == 2) return 512 + (cb % 16);
      return cb;
   endfunction

   task automatic chk(bit ok, string tag, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_ready();
      while (ready !== 1'b1) @(negedge clk);
   endtask

   task automatic we_cycle(logic c, logic a, logic [7:0] d);
      @(negedge clk);
      cle = c; ale = a; io_in = d; we_n = 1'b0;
      @(negedge clk);
      we_n = 1'b1;
      @(negedge clk);
      cle = 1'b0; ale = 1'b0;
   endtask

   task automatic cmd(logic [7:0] code);
      wait_ready();
      we_cycle(1'b1, 1'b0, code);
      if (code == 8'h00) m_region = 0;
      else if (code == 8'h01) m_region = 1;
      else if (code == 8'h50) m_region = 2;
   endtask

   task automatic model_setup(int cb, int row);
      m_spare = (m_region == 2) ? 1 : 0;
      m_col = first_col(m_region, cb);
      m_row = row & 16'h3FFF;
      if (m_region == 1) m_region = 0;
   endtask

   task automatic addr3(int cb, int row);
      wait_ready();
      we_cycle(1'b0, 1'b1, 8'(cb));
      we_cycle(1'b0, 1'b1, 8'(row));
      we_cycle(1'b0, 1'b1, 8'((row >> 8) & 63));
      model_setup(cb, row);
   endtask

   task automatic advance();
      if (m_col == last_col(m_spare, skip_spare)) begin
         m_row = (m_row + 1) & 16'h3FFF;
         m_col = (m_spare != 0) ? 512 : 0;
      end else begin
         m_col++;
      end
   endtask

   task automatic re_pulse(output logic [7:0] b);
      @(negedge clk);
      re_n = 1'b0;
      @(negedge clk);
      b = io_out;
      re_n = 1'b1;
   endtask

   task automatic rd(int n, string tag);
      for (int i = 0; i < n; i++) begin
         logic [7:0] b, e;
         wait_ready();
         e = exp_byte(m_row, m_col);
         re_pulse(b);
         chk(b == e, tag, int'(b), int'(e));
         advance();
      end
   endtask

   task automatic addr3_measure(int cb, int row, output int lowcnt);
      wait_ready();
      we_cycle(1'b0, 1'b1, 8'(cb));
      we_cycle(1'b0, 1'b1, 8'(row));
      @(negedge clk);
      ale = 1'b1; io_in = 8'((row >> 8) & 63); we_n = 1'b0;
      @(negedge clk);
      we_n = 1'b1;
      lowcnt = 0;
      @(negedge clk);
      ale = 1'b0;
      while (ready == 1'b0 && lowcnt < 4 * TR) begin
         lowcnt++;
         @(negedge clk);
      end
      model_setup(cb, row);
   endtask

   task automatic rd_last_measure(string tag, output int lowcnt);
      logic [7:0] b, e;
      wait_ready();
      e = exp_byte(m_row, m_col);
      re_pulse(b);
      chk(b == e, tag, int'(b), int'(e));
      advance();
      lowcnt = 0;
      while (ready == 1'b0 && lowcnt < 4 * TR) begin
         lowcnt++;
         @(negedge clk);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin : main
      int lc;
      logic [7:0] hold_b, b;
      logic [7:0] codes [3];
      void'($urandom(32'd4321));
      codes[0] = 8'h00; codes[1] = 8'h01; codes[2] = 8'h50;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ready == 1'b1, "R1 ready after reset", int'(ready), 1);
      chk(io_out == 8'h00, "R1 io_out after reset", int'(io_out), 0);

      // R1: default first-half mode without any command
      addr3(8'h10, 5);
      rd(4, "R1");

      // R2 and R3: setup with 00h, exact busy length
      cmd(8'h00);
      addr3_measure(8'h20, 16'h0123, lc);
      chk(lc == TR + 2, "R3 setup busy", lc, TR + 2);
      rd(3, "R2");

      // R6 with skip_spare=1, page crossing at 511, R3 auto-load length
      skip_spare = 1'b1;
      cmd(8'h01);
      addr3(8'hFC, 9);
      rd(3, "R6");
      rd_last_measure("R5", lc);
      chk(lc == TR + 1, "R3 next page busy", lc, TR + 1);
      rd(2, "R6");
      addr3(8'h05, 20);
      rd(1, "R6");

      // R5: skip_spare=0 reads through the spare tail to 527
      skip_spare = 1'b0;
      cmd(8'h01);
      addr3(8'hFE, 30);
      rd(20, "R5");

      // R7: spare pointer, high nibble ignored, persists
      skip_spare = 1'b1;
      cmd(8'h50);
      addr3(8'hAC, 40);
      rd(6, "R7");
      addr3(8'h03, 50);
      rd(2, "R7");
      cmd(8'h90);                 // R10: unknown code
      addr3(8'h01, 51);
      rd(2, "R10");
      cmd(8'h00);
      addr3(8'h02, 52);
      rd(1, "R7");

      // R8: chip enable high ends the sequence
      cmd(8'h00);
      addr3(8'h30, 80);
      rd(2, "R8");
      @(negedge clk);
      ce_n = 1'b1;
      hold_b = io_out;
      re_pulse(b);
      re_pulse(b);
      chk(io_out == hold_b, "R8 output with ce high", int'(io_out), int'(hold_b));
      chk(ready == 1'b1, "R8 no load with ce high", int'(ready), 1);
      @(negedge clk);
      ce_n = 1'b0;
      re_pulse(b);
      chk(io_out == hold_b, "R8 no output after sequence end", int'(io_out), int'(hold_b));

      // R9 and R11: cycles and strobes during busy are ignored
      cmd(8'h00);
      addr3(8'h00, 60);
      hold_b = io_out;
      we_cycle(1'b1, 1'b0, 8'h50);
      we_cycle(1'b0, 1'b1, 8'h0F);
      we_cycle(1'b0, 1'b1, 8'd61);
      we_cycle(1'b0, 1'b1, 8'h00);
      re_pulse(b);
      re_pulse(b);
      chk(ready == 1'b0, "R11 still busy", int'(ready), 0);
      chk(io_out == hold_b, "R11 output during busy", int'(io_out), int'(hold_b));
      rd(2, "R9");

      // R10: simultaneous cle and ale is discarded
      cmd(8'h00);
      wait_ready();
      we_cycle(1'b0, 1'b1, 8'h40);
      we_cycle(1'b1, 1'b1, 8'h77);
      we_cycle(1'b0, 1'b1, 8'd70);
      we_cycle(1'b0, 1'b1, 8'h00);
      model_setup(8'h40, 70);
      rd(3, "R10");

      // seeded random setups, R4 stepping, crossings in second half
      for (int i = 0; i < 18; i++) begin
         int k, cb, row, n;
         k = int'($urandom % 4);
         if (k < 3) cmd(codes[k]);
         skip_spare = 1'($urandom % 2);
         cb = int'($urandom % 256);
         if (m_region == 1) cb = 240 + int'($urandom % 16);
         row = int'($urandom % 16384);
         n = 1 + int'($urandom % 24);
         addr3(cb, row);
         rd(n, "R4");
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule